// File: doc/BRIEF.md
# Boundary Scan Cell Chain

This block is a chain of two-rank boundary scan cells placed between a set of device pins and the core logic. Each cell carries one parallel signal. When the signal goes into the device, it passes from a pin toward the core. When it goes out of the device, it passes from the core toward a pin. The first rank of each cell can load the parallel value it sees, or it can take the bit held by its upstream neighbour. In the second way the first ranks together form one serial register, from the test data input to the test data output. The second rank is a holding register. It copies the first rank only when an update strobe is given.

An external test access controller and an instruction decoder drive the capture, shift, update and mode inputs. The controller state machine is not part of this block. With mode low, every parallel signal passes through unchanged while its value is sampled and shifted out. With mode high, every parallel output is driven from the holding rank. Shifted-in patterns then reach the pins, and the values on the input pins are captured into the chain. A new pattern can be shifted in while the holding rank keeps the driven values steady. Those values change only when the update strobe arrives.

Top module: `bsr_chain`

## Requirements
- R1: After an asynchronous reset (rst_ni low), both ranks of every cell hold 0. tdo_o therefore reads 0, and with mode_i = 1 every bit of par_o reads 0.
- R2: On a clock edge with capture_i = 1, cell k's first rank loads par_i[k].
- R3: On a clock edge with shift_i = 1 and capture_i = 0, cell 0's first rank loads tdi_i and cell k loads from cell k-1. tdo_o always shows the first rank of cell N_CELLS-1.
- R4: When capture_i and shift_i are both 1 on an edge, capture wins and no shifting takes place.
- R5: On an edge with capture_i = 0 and shift_i = 0, the first rank keeps its value.
- R6: On an edge with update_i = 1, every cell's second rank loads that cell's first rank. With update_i = 0 the second rank keeps its value, including while the chain shifts or captures.
- R7: With mode_i = 0, par_o equals par_i bit for bit, with no clock delay.
- R8: With mode_i = 1, par_o[k] equals the second rank of cell k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Test clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tdi_i | input | 1 | Serial test data into cell 0 |
| capture_i | input | 1 | Load par_i into the first rank |
| shift_i | input | 1 | Move the first rank one cell toward tdo_o |
| update_i | input | 1 | Copy the first rank into the second rank |
| mode_i | input | 1 | 0 = pass-through, 1 = drive from the second rank |
| par_i | input | N_CELLS | Parallel values from pins or core |
| par_o | output | N_CELLS | Parallel values toward core or pins |
| tdo_o | output | 1 | Serial test data out of the last cell |

## Verification
The properties assume that the control inputs are stable around each rising clock edge. They place no limits on combinations of the controls: capture and shift together, and update during a shift, are both legal. The bench changes every input only on the falling edge. Its directed phases cover the reset state, capture followed by a full unload, a full load followed by an update, the case where capture and shift are both set, idle holding, and shifting with the update strobe held low in drive mode. After these phases it applies random control and data words, with mode toggled across the run.

// File: rtl/bsr_pkg.sv
package bsr_pkg;

  typedef enum logic [1:0] {
    CELL_HOLD    = 2'd0,
    CELL_SHIFT   = 2'd1,
    CELL_CAPTURE = 2'd2
  } cell_op_e;

  // capture outranks shift
  function automatic cell_op_e decode_op(input logic capture, input logic shift);
    if (capture)    return CELL_CAPTURE;
    else if (shift) return CELL_SHIFT;
    else            return CELL_HOLD;
  endfunction

endpackage

// File: rtl/bsr_capture_rank.sv
module bsr_capture_rank
  import bsr_pkg::*;
#(
  parameter int unsigned N_CELLS = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  cell_op_e           op_i,
  input  logic               tdi_i,
  input  logic [N_CELLS-1:0] par_i,
  output logic [N_CELLS-1:0] cap_o,
  output logic               tdo_o
);

  logic [N_CELLS:0]   link;
  logic [N_CELLS-1:0] cap_q;

  assign link[0] = tdi_i;

  for (genvar k = 0; k < N_CELLS; k++) begin : g_cell
    logic nxt;

    always_comb begin
      unique case (op_i)
        CELL_CAPTURE: nxt = par_i[k];
        CELL_SHIFT:   nxt = link[k];
        default:      nxt = cap_q[k];
      endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cap_q[k] <= 1'b0;
      else         cap_q[k] <= nxt;
    end

    assign link[k+1] = cap_q[k];
  end

  assign cap_o = cap_q;
  assign tdo_o = link[N_CELLS];

endmodule

// File: rtl/bsr_update_rank.sv
module bsr_update_rank #(
  parameter int unsigned N_CELLS = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               update_i,
  input  logic [N_CELLS-1:0] cap_i,
  output logic [N_CELLS-1:0] upd_o
);

  for (genvar k = 0; k < N_CELLS; k++) begin : g_cell
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       upd_o[k] <= 1'b0;
      else if (update_i) upd_o[k] <= cap_i[k];
    end
  end

endmodule

// File: rtl/bsr_out_mux.sv
module bsr_out_mux #(
  parameter int unsigned N_CELLS = 8
) (
  input  logic               mode_i,
  input  logic [N_CELLS-1:0] par_i,
  input  logic [N_CELLS-1:0] upd_i,
  output logic [N_CELLS-1:0] par_o
);

  for (genvar k = 0; k < N_CELLS; k++) begin : g_cell
    assign par_o[k] = mode_i ? upd_i[k] : par_i[k];
  end

endmodule

// File: rtl/bsr_chain.sv
module bsr_chain
  import bsr_pkg::*;
#(
  parameter int unsigned N_CELLS = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tdi_i,
  input  logic               capture_i,
  input  logic               shift_i,
  input  logic               update_i,
  input  logic               mode_i,
  input  logic [N_CELLS-1:0] par_i,
  output logic [N_CELLS-1:0] par_o,
  output logic               tdo_o
);

  cell_op_e           op;
  logic [N_CELLS-1:0] cap_q;
  logic [N_CELLS-1:0] upd_q;

  assign op = decode_op(capture_i, shift_i);

  bsr_capture_rank #(.N_CELLS(N_CELLS)) i_capture_rank (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .op_i   (op),
    .tdi_i  (tdi_i),
    .par_i  (par_i),
    .cap_o  (cap_q),
    .tdo_o  (tdo_o)
  );

  bsr_update_rank #(.N_CELLS(N_CELLS)) i_update_rank (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .update_i (update_i),
    .cap_i    (cap_q),
    .upd_o    (upd_q)
  );

  bsr_out_mux #(.N_CELLS(N_CELLS)) i_out_mux (
    .mode_i (mode_i),
    .par_i  (par_i),
    .upd_i  (upd_q),
    .par_o  (par_o)
  );

endmodule

// File: rtl/bsr_chain_chk.sv
module bsr_chain_chk #(
  parameter int unsigned N_CELLS = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               tdi_i,
  input logic               capture_i,
  input logic               shift_i,
  input logic               update_i,
  input logic               mode_i,
  input logic [N_CELLS-1:0] par_i,
  input logic [N_CELLS-1:0] par_o,
  input logic               tdo_o,
  input logic [N_CELLS-1:0] cap_q,
  input logic [N_CELLS-1:0] upd_q
);

  // R2 R4
  capture_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    capture_i |=> cap_q == $past(par_i));

  // R3
  shift_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_i && !capture_i) |=> cap_q[0] == $past(tdi_i));

  // R3
  shift_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_i && !capture_i) |=> tdo_o == $past(cap_q[N_CELLS-2]));

  // R5
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!shift_i && !capture_i) |=> $stable(cap_q));

  // R6
  update_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    update_i |=> upd_q == $past(cap_q));

  // R6
  update_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !update_i |=> $stable(upd_q));

  // R7
  pass_through_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_i |-> par_o == par_i);

  // R8
  drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i |-> par_o == upd_q);

endmodule

bind bsr_chain bsr_chain_chk #(.N_CELLS(N_CELLS)) i_bsr_chain_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .tdi_i     (tdi_i),
  .capture_i (capture_i),
  .shift_i   (shift_i),
  .update_i  (update_i),
  .mode_i    (mode_i),
  .par_i     (par_i),
  .par_o     (par_o),
  .tdo_o     (tdo_o),
  .cap_q     (cap_q),
  .upd_q     (upd_q)
);

// File: tb/test_bsr_chain.sv
`timescale 1ns/1ps
module test_bsr_chain;

  localparam int N = 8;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         tdi_i = 1'b0;
  logic         capture_i = 1'b0;
  logic         shift_i = 1'b0;
  logic         update_i = 1'b0;
  logic         mode_i = 1'b0;
  logic [N-1:0] par_i = '0;
  logic [N-1:0] par_o;
  logic         tdo_o;

  int    checks = 0;
  int    errors = 0;
  string phase  = "R1";

  always #10 clk_i = ~clk_i;

  bsr_chain #(.N_CELLS(N)) i_bsr_chain (
    .clk_i(clk_i), .rst_ni(rst_ni), .tdi_i(tdi_i), .capture_i(capture_i),
    .shift_i(shift_i), .update_i(update_i), .mode_i(mode_i),
    .par_i(par_i), .par_o(par_o), .tdo_o(tdo_o)
  );

  // reference: queue index 0 is the cell nearest tdi_i
  bit m_cap[$];
  bit m_upd[N];

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_cap.delete();
      for (int k = 0; k < N; k++) begin
        m_cap.push_back(1'b0);
        m_upd[k] = 1'b0;
      end
    end else begin
      bit snap[$];
      snap = m_cap;
      if (update_i)
        for (int k = 0; k < N; k++) m_upd[k] = snap[k];
      if (capture_i) begin
        for (int k = 0; k < N; k++) m_cap[k] = par_i[k];
      end else if (shift_i) begin
        m_cap.push_front(tdi_i);
        void'(m_cap.pop_back());
      end
    end
  end

  task automatic check(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %0h expected %0h at %0t", req, got, exp, $time);
    end
  endtask

  task automatic compare();
    logic [N-1:0] exp_par;
    check(phase, tdo_o, m_cap[N-1]);
    for (int k = 0; k < N; k++) exp_par[k] = mode_i ? m_upd[k] : par_i[k];
    check(mode_i ? "R8" : "R7", par_o, exp_par);
  endtask

  // inputs held from one falling edge to the next; compare after the rising edge
  task automatic step(bit c, bit s, bit u, bit m, bit d, logic [N-1:0] p);
    capture_i = c; shift_i = s; update_i = u; mode_i = m; tdi_i = d; par_i = p;
    @(posedge clk_i);
    @(negedge clk_i);
    compare();
  endtask

  initial begin
    #4_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [N-1:0] pat;
    repeat (3) @(negedge clk_i);
    mode_i = 1'b1;
    #1;
    phase = "R1";
    check("R1", tdo_o, 0);
    check("R1", par_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    step(0, 0, 0, 1, 1, 8'hFF);

    // capture then unload
    phase = "R2";
    step(1, 0, 0, 0, 0, 8'hA5);
    phase = "R3";
    for (int i = 0; i < N; i++) step(0, 1, 0, 0, 1, 8'h3C);

    // load a pattern, then update and drive
    pat = 8'h96;
    for (int i = 0; i < N; i++) step(0, 1, 0, 1, pat[N-1-i], 8'h00);
    phase = "R6";
    step(0, 0, 1, 1, 0, 8'h00);
    step(0, 0, 0, 1, 0, 8'h0F);
    step(0, 0, 0, 0, 0, 8'h0F);

    // capture wins over shift
    phase = "R4";
    step(1, 1, 0, 1, 1, 8'h5A);
    step(0, 0, 0, 1, 1, 8'h00);

    // idle hold
    phase = "R5";
    for (int i = 0; i < 4; i++) step(0, 0, 0, 1, ~tdi_i, ~par_i);

    // shifting without update keeps driven values
    phase = "R6";
    for (int i = 0; i < N; i++) step(0, 1, 0, 1, i[0], 8'h00);
    step(0, 0, 1, 1, 0, 8'h00);

    phase = "R3";
    for (int i = 0; i < 400; i++)
      step($urandom_range(0, 3) == 0, $urandom_range(0, 1) == 1,
           $urandom_range(0, 4) == 0, $urandom_range(0, 1) == 1,
           $urandom_range(0, 1) == 1, N'($urandom));

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule